// File: doc/BRIEF.md
# Multiply-Accumulate Post-Adder with Round and Saturate

This block is the datapath that follows four signed 18x18 multipliers. Each input beat carries four 36-bit signed products. Two pair adders form the sums of the low pair and the high pair. A compile-time switch places an optional register after the pair adders. That register splits the long path into two shorter ones and costs one cycle of latency. A 44-bit second-stage adder then combines the two pair sums. It runs in one of three modes, chosen for each beat: a plain sum of four products, a running accumulator, or a chained sum that also adds a 44-bit cascade word from a neighbouring slice. The adder has no data inputs of its own beyond these.

A selector picks the word that goes to the output stage. It can pick a single product, either pair sum, or the second-stage result. A rounding unit and then a saturating unit may process that word, and each is switched on at run time. Rounding adds half of the least significant kept bit and then clears the bits below it. Saturation clamps the value to the signed range of a narrower output width and flags the clamp. When both switches are off, the selected word goes straight to the output register.

Data enters and leaves through valid/ready handshakes. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. The pipeline advances as one unit. `in_ready` is high whenever the output register is empty or is being consumed in that cycle. While a result waits with `out_ready` low, the whole pipeline holds, the accumulator included.

Top module: `mac_post_adder`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: With `mode`=0 and `src_sel`=3, and both the round and saturate switches off, the result is the 44-bit two's-complement sum of the four sign-extended products. The 36-bit product k sits at bits [36k+35:36k] of `prod`.
- R3: With `mode`=1, the result is the four-product sum plus the accumulator, wrapped to 44 bits. The accumulator then takes this value. When `acc_clr` is 1 on that beat, the prior accumulator value is replaced by 0. The accumulator changes only on accepted beats with `mode`=1, whatever `src_sel` is.
- R4: With `mode`=2, the result is the four-product sum plus the signed 44-bit `chain_in`, wrapped to 44 bits.
- R5: `src_sel` chooses the output word: 0 gives product 0, 1 gives product 0 + product 1, 2 gives product 2 + product 3, and 3 gives the second-stage result.
- R6: With `rnd_en`=1, the selected value v becomes (v + 2^(RND_N-1)) with its low RND_N bits cleared. The sum is formed at 45 bits, and the result is truncated to 44 bits when saturation is off.
- R7: With `sat_en`=1, a rounded value above 2^(OW-1)-1 or below -2^(OW-1) is replaced by that bound, sign-extended to 44 bits, and `out_ovf` is 1 with the same result. Otherwise `out_ovf` is 0.
- R8: Rounding happens before saturation. A value just below the positive bound that rounds past it saturates and sets `out_ovf`.
- R9: With `out_ready` held at 1, a beat accepted on one edge appears with `out_valid` exactly 1+USE_PIPE edges later, and results leave in acceptance order.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_data` and `out_ovf` hold their values. No beat is lost or repeated under random back-pressure.
- R11: `mode`=3 behaves exactly like `mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| prod | input | 4*PW | Four signed products, product k at bits [PW*k+PW-1:PW*k] |
| chain_in | input | AW | Cascade word from the neighbouring slice |
| mode | input | 2 | 0 sum of four, 1 accumulate, 2 chained, 3 sum of four |
| src_sel | input | 2 | Output word: 0 product 0, 1 low pair, 2 high pair, 3 second stage |
| rnd_en | input | 1 | Enable rounding for this beat |
| sat_en | input | 1 | Enable saturation for this beat |
| acc_clr | input | 1 | Start the accumulation from zero on this beat |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | AW | Result, 44-bit two's complement |
| out_ovf | output | 1 | Result was clamped by saturation |

## Verification
The bench drives the accumulator through its 44-bit wrap. A wrong adder width or a missing wrap would send the running sum off its expected course and make every later beat mismatch. It places values right at the rounding midpoint on both signs. A unit that rounded toward zero, or cleared bits before adding the half, would be off by one step of 2^RND_N. It also places a value just below the positive bound, so a unit that saturated before rounding would miss the clamp and the overflow flag. Random back-pressure across all modes exposes a pipeline that drops a beat, repeats one, or advances the accumulator during a stall: the results would fall out of order with the queued model.

// File: rtl/mac_pa_pkg.sv
package mac_pa_pkg;
  typedef enum logic [1:0] {
    MODE_SUM4  = 2'd0,
    MODE_ACC   = 2'd1,
    MODE_CHAIN = 2'd2,
    MODE_SUM4B = 2'd3
  } mac_mode_e;

  typedef enum logic [1:0] {
    SRC_PROD    = 2'd0,
    SRC_PAIR_LO = 2'd1,
    SRC_PAIR_HI = 2'd2,
    SRC_FINAL   = 2'd3
  } rs_src_e;
endpackage

// File: rtl/mac_pair_stage.sv
module mac_pair_stage #(
  parameter int PW       = 36,
  parameter int AW       = 44,
  parameter int USE_PIPE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_valid,
  input  logic [4*PW-1:0] prod,
  input  logic [AW-1:0] chain_in,
  input  logic [1:0]    mode,
  input  logic [1:0]    src_sel,
  input  logic          rnd_en,
  input  logic          sat_en,
  input  logic          acc_clr,
  output logic          m_valid,
  output logic [AW-1:0] m_single,
  output logic [AW-1:0] m_lo,
  output logic [AW-1:0] m_hi,
  output logic [AW-1:0] m_chain,
  output logic [1:0]    m_mode,
  output logic [1:0]    m_src,
  output logic          m_rnd,
  output logic          m_sat,
  output logic          m_clr
);
  logic [AW-1:0] pext [4];
  logic [AW-1:0] c_lo, c_hi;

  for (genvar g = 0; g < 4; g++) begin : g_sext
    assign pext[g] = {{(AW-PW){prod[g*PW+PW-1]}}, prod[g*PW +: PW]};
  end

  assign c_lo = pext[0] + pext[1];
  assign c_hi = pext[2] + pext[3];

  if (USE_PIPE != 0) begin : g_pipe
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m_valid <= 1'b0;
      end else if (adv) begin
        m_valid <= in_valid;
      end
    end
    always_ff @(posedge clk) begin
      if (adv) begin
        m_single <= pext[0];
        m_lo     <= c_lo;
        m_hi     <= c_hi;
        m_chain  <= chain_in;
        m_mode   <= mode;
        m_src    <= src_sel;
        m_rnd    <= rnd_en;
        m_sat    <= sat_en;
        m_clr    <= acc_clr;
      end
    end
  end else begin : g_bypass
    assign m_valid  = in_valid;
    assign m_single = pext[0];
    assign m_lo     = c_lo;
    assign m_hi     = c_hi;
    assign m_chain  = chain_in;
    assign m_mode   = mode;
    assign m_src    = src_sel;
    assign m_rnd    = rnd_en;
    assign m_sat    = sat_en;
    assign m_clr    = acc_clr;
  end
endmodule

// File: rtl/mac_second_stage.sv
module mac_second_stage
  import mac_pa_pkg::*;
#(
  parameter int AW = 44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] chain,
  input  logic [1:0]    mode,
  input  logic          clr,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] acc_q;
  logic [AW-1:0] third;

  always_comb begin
    case (mode)
      MODE_ACC:   third = clr ? '0 : acc_q;
      MODE_CHAIN: third = chain;
      default:    third = '0;
    endcase
    sum = lo + hi + third;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (fire && (mode == MODE_ACC)) begin
      acc_q <= sum;
    end
  end
endmodule

// File: rtl/mac_round_sat.sv
module mac_round_sat #(
  parameter int AW    = 44,
  parameter int OW    = 32,
  parameter int RND_N = 8
) (
  input  logic [AW-1:0] val,
  input  logic          rnd_en,
  input  logic          sat_en,
  output logic [AW-1:0] res,
  output logic          ovf
);
  localparam logic [AW:0] HALF = (AW+1)'(1) << (RND_N-1);
  localparam logic [AW:0] KEEP = ~(((AW+1)'(1) << RND_N) - (AW+1)'(1));
  localparam logic signed [AW:0] SMAX = (AW+1)'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [AW:0] SMIN = -SMAX - (AW+1)'(1);

  logic signed [AW:0] ext, rv;

  always_comb begin
    ext = {val[AW-1], val};
    rv  = rnd_en ? ((ext + HALF) & KEEP) : ext;
    ovf = 1'b0;
    res = rv[AW-1:0];
    if (sat_en) begin
      if (rv > SMAX) begin
        res = SMAX[AW-1:0];
        ovf = 1'b1;
      end else if (rv < SMIN) begin
        res = SMIN[AW-1:0];
        ovf = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mac_post_adder.sv
module mac_post_adder
  import mac_pa_pkg::*;
#(
  parameter int PW       = 36,
  parameter int AW       = 44,
  parameter int OW       = 32,
  parameter int RND_N    = 8,
  parameter int USE_PIPE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [4*PW-1:0] prod,
  input  logic [AW-1:0]   chain_in,
  input  logic [1:0]      mode,
  input  logic [1:0]      src_sel,
  input  logic            rnd_en,
  input  logic            sat_en,
  input  logic            acc_clr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_data,
  output logic            out_ovf
);
  logic          adv;
  logic          m_valid, m_rnd, m_sat, m_clr;
  logic [AW-1:0] m_single, m_lo, m_hi, m_chain;
  logic [1:0]    m_mode, m_src;
  logic [AW-1:0] s2_sum, pick, rs_res;
  logic          rs_ovf;

  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  mac_pair_stage #(.PW(PW), .AW(AW), .USE_PIPE(USE_PIPE)) u_pair (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid), .prod(prod),
    .chain_in(chain_in), .mode(mode), .src_sel(src_sel), .rnd_en(rnd_en),
    .sat_en(sat_en), .acc_clr(acc_clr), .m_valid(m_valid), .m_single(m_single),
    .m_lo(m_lo), .m_hi(m_hi), .m_chain(m_chain), .m_mode(m_mode), .m_src(m_src),
    .m_rnd(m_rnd), .m_sat(m_sat), .m_clr(m_clr)
  );

  mac_second_stage #(.AW(AW)) u_s2 (
    .clk(clk), .rst_n(rst_n), .fire(adv && m_valid), .lo(m_lo), .hi(m_hi),
    .chain(m_chain), .mode(m_mode), .clr(m_clr), .sum(s2_sum)
  );

  always_comb begin
    case (m_src)
      SRC_PROD:    pick = m_single;
      SRC_PAIR_LO: pick = m_lo;
      SRC_PAIR_HI: pick = m_hi;
      default:     pick = s2_sum;
    endcase
  end

  mac_round_sat #(.AW(AW), .OW(OW), .RND_N(RND_N)) u_rs (
    .val(pick), .rnd_en(m_rnd), .sat_en(m_sat), .res(rs_res), .ovf(rs_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= m_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_data <= rs_res;
      out_ovf  <= rs_ovf;
    end
  end
endmodule

// File: rtl/mac_post_adder_chk.sv
module mac_post_adder_chk #(
  parameter int AW       = 44,
  parameter int OW       = 32,
  parameter int USE_PIPE = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_data,
  input logic          out_ovf
);
  localparam logic [AW-1:0] BMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic [AW-1:0] BMIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  // R1: reset empties the output register
  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R10: a stalled result holds still
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf)));

  // R10: no acceptance while the output is blocked
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R1: an empty output register always takes data
  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7: a flagged result sits exactly on a bound
  a_r7_ovf_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> ((out_data == BMAX) || (out_data == BMIN)));

  if (USE_PIPE == 0) begin : g_lat0
    // R9: one-cycle latency without the middle register
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
  end
endmodule

bind mac_post_adder mac_post_adder_chk #(.AW(AW), .OW(OW), .USE_PIPE(USE_PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/tb_mac_post_adder.sv
module tb_mac_post_adder;
  localparam int PW = 36, AW = 44, OW = 32, RND_N = 8, USE_PIPE = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0, in_ready;
  logic [4*PW-1:0] prod = '0;
  logic [AW-1:0]   chain_in = '0;
  logic [1:0]      mode = 2'd0, src_sel = 2'd3;
  logic            rnd_en = 1'b0, sat_en = 1'b0, acc_clr = 1'b0;
  logic            out_valid, out_ready = 1'b1, out_ovf;
  logic [AW-1:0]   out_data;

  mac_post_adder #(.PW(PW), .AW(AW), .OW(OW), .RND_N(RND_N), .USE_PIPE(USE_PIPE)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .prod(prod),
    .chain_in(chain_in), .mode(mode), .src_sel(src_sel), .rnd_en(rnd_en),
    .sat_en(sat_en), .acc_clr(acc_clr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  longint acc_m = 0;
  longint exp_q[$];
  bit     ovf_q[$];
  int     cyc_q[$];
  string  tag_q[$];
  bit     lat_q[$];
  bit     lat_chk = 1'b0, bp_on = 1'b0, done = 1'b0;
  string  cur_tag = "R1";

  function automatic longint wrap(longint x);
    longint m = x & ((64'sd1 <<< AW) - 1);
    if (m[AW-1]) m = m - (64'sd1 <<< AW);
    return m;
  endfunction

  function automatic longint pv(int k);
    logic signed [PW-1:0] s = prod[k*PW +: PW];
    return longint'(s);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic model_push();
    longint s4, base, v, st, r, hi, lo;
    bit o = 1'b0;
    s4 = pv(0) + pv(1) + pv(2) + pv(3);
    base = 0;
    if (mode == 2'd1) base = acc_clr ? 0 : acc_m;
    else if (mode == 2'd2) base = longint'($signed(chain_in));
    st = wrap(s4 + base);
    if (mode == 2'd1) acc_m = st;
    case (src_sel)
      2'd0: v = pv(0);
      2'd1: v = pv(0) + pv(1);
      2'd2: v = pv(2) + pv(3);
      default: v = st;
    endcase
    if (rnd_en) v = (v + (64'sd1 <<< (RND_N-1))) & ~((64'sd1 <<< RND_N) - 1);
    hi = (64'sd1 <<< (OW-1)) - 1;
    lo = -(64'sd1 <<< (OW-1));
    r = wrap(v);
    if (sat_en && v > hi) begin r = hi; o = 1'b1; end
    else if (sat_en && v < lo) begin r = lo; o = 1'b1; end
    exp_q.push_back(r); ovf_q.push_back(o); cyc_q.push_back(cyc);
    tag_q.push_back(cur_tag); lat_q.push_back(lat_chk);
  endtask

  always @(negedge clk) begin
    logic signed [AW-1:0] od;
    longint e; bit eo; int c; string t; bit l;
    cyc++;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        od = out_data;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", longint'(od), 0);
        end else begin
          e = exp_q.pop_front(); eo = ovf_q.pop_front(); c = cyc_q.pop_front();
          t = tag_q.pop_front(); l = lat_q.pop_front();
          check(longint'(od) == e, t, longint'(od), e);
          check(out_ovf == eo, {t, " ovf"}, longint'(out_ovf), longint'(eo));
          if (l) check(cyc - c == 1 + USE_PIPE, "R9 latency", cyc - c, 1 + USE_PIPE);
        end
      end
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R10 ready", longint'(in_ready), 0);
      if (in_valid && in_ready) model_push();
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (bp_on) out_ready = ($urandom() % 3) != 0;
  end

  task automatic send(longint p0, longint p1, longint p2, longint p3, longint ch,
                      int md, int src, bit rn, bit st, bit cl);
    bit ok;
    prod = {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    chain_in = AW'(ch); mode = 2'(md); src_sel = 2'(src);
    rnd_en = rn; sat_en = st; acc_clr = cl; in_valid = 1'b1;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
  endtask

  task automatic idle_drain();
    in_valid = 1'b0;
    bp_on = 1'b0;
    out_ready = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  function automatic longint rp();
    logic [PW-1:0] v = PW'({$urandom(), $urandom()});
    logic signed [PW-1:0] s = v;
    return longint'(s);
  endfunction

  localparam longint PMAX = (64'sd1 <<< (PW-1)) - 1;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);
    @(posedge clk); #1;

    // R2 / R9: plain sum of four, back-to-back, latency checked
    cur_tag = "R2"; lat_chk = 1'b1;
    send(1, 2, 3, 4, 0, 0, 3, 0, 0, 0);
    send(-5, 7, -100, 1000, 0, 0, 3, 0, 0, 0);
    send(PMAX, PMAX, PMAX, PMAX, 0, 0, 3, 0, 0, 0);
    send(-PMAX-1, -PMAX-1, -PMAX-1, -PMAX-1, 0, 0, 3, 0, 0, 0);
    for (int i = 0; i < 6; i++) send(rp(), rp(), rp(), rp(), 0, 0, 3, 0, 0, 0);
    idle_drain();
    lat_chk = 1'b0;

    // R5: output word selection
    cur_tag = "R5";
    for (int s = 0; s < 3; s++) begin
      send(123456, -654321, 777, -999999, 0, 0, s, 0, 0, 0);
      send(rp(), rp(), rp(), rp(), 0, 0, s, 0, 0, 0);
    end
    idle_drain();

    // R3: accumulate with clear and 44-bit wrap
    cur_tag = "R3";
    send(10, 20, 30, 40, 0, 1, 3, 0, 0, 1);
    send(1, 1, 1, 1, 0, 1, 3, 0, 0, 0);
    send(5, 5, 5, 5, 0, 0, 3, 0, 0, 0);
    send(1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    send(-3, 0, 0, 0, 0, 1, 3, 0, 0, 0);
    for (int i = 0; i < 80; i++) send(PMAX, PMAX, PMAX, PMAX, 0, 1, 3, 0, 0, 0);
    send(7, 7, 7, 7, 0, 1, 3, 0, 0, 1);
    idle_drain();

    // R4: chained sum including wrap
    cur_tag = "R4";
    send(1, 2, 3, 4, 1000, 2, 3, 0, 0, 0);
    send(1, 2, 3, 4, -5000, 2, 3, 0, 0, 0);
    send(PMAX, PMAX, PMAX, PMAX, (64'sd1 <<< (AW-1)) - 1, 2, 3, 0, 0, 0);
    idle_drain();

    // R11: mode 3 equals mode 0
    cur_tag = "R11";
    send(11, -22, 33, -44, 999, 3, 3, 0, 0, 0);
    send(rp(), rp(), rp(), rp(), 12345, 3, 3, 0, 0, 0);
    idle_drain();

    // R6: rounding at the midpoint and around it, saturation off
    cur_tag = "R6";
    send(127, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    send(128, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    send(-128, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    send(-129, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    send(383, 1, 0, 0, 0, 0, 1, 1, 0, 0);
    send(PMAX, PMAX, PMAX, PMAX, (64'sd1 <<< (AW-1)) - 2, 2, 3, 1, 0, 0);
    idle_drain();

    // R7: saturation both ways, and in range
    cur_tag = "R7";
    send(64'sd1 <<< 34, 64'sd1 <<< 34, 64'sd1 <<< 34, 64'sd1 <<< 34, 0, 0, 3, 0, 1, 0);
    send(-(64'sd1 <<< 34), -(64'sd1 <<< 34), -(64'sd1 <<< 34), -(64'sd1 <<< 34), 0, 0, 3, 0, 1, 0);
    send(64'sd1 <<< 34, 64'sd1 <<< 34, 64'sd1 <<< 34, 64'sd1 <<< 34, 0, 0, 3, 0, 0, 0);
    send(-(64'sd1 <<< 31), 0, 0, 0, 0, 0, 0, 0, 1, 0);
    send(12345, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle_drain();

    // R8: round pushes a value past the bound before the clamp
    cur_tag = "R8";
    send((64'sd1 <<< 31) - 11, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    send((64'sd1 <<< 31) - 11, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    send(-(64'sd1 <<< 31) - 100, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    idle_drain();

    // R10: random back-pressure across all modes
    cur_tag = "R10";
    bp_on = 1'b1;
    for (int i = 0; i < 300; i++)
      send(rp(), rp(), rp(), rp(), rp() <<< 8, int'($urandom() % 4), int'($urandom() % 4),
           1'($urandom()), 1'($urandom()), ($urandom() % 8) == 0);
    idle_drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule